// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block times every machine cycle of an 8-bit external memory interface. It runs from the oscillator-rate clock. A divide-by-two phase stage feeds a state counter, so a machine cycle is 6 states of 2 phases each, 12 clocks in all. From that count the block produces the address-latch strobe, the active-low program-store read strobe, and the active-low data read and write strobes. It also produces two select codes that tell the port drivers what to put on the multiplexed low address/data lines and on the high address lines.

Each half machine cycle is one fetch slot. At the end of every half, the block decides whether the next half fetches from internal or external code memory. The decision uses the fetch address and the internal-code-enable pin. A CPU asks for an external data access by raising a request at the end of the first half of a machine cycle. The block then spends the second half presenting the data address. It spends the first half of the following machine cycle driving the read or write strobe. One address-latch pulse and two program-store pulses are dropped for each such access.

Top module: `xbus_strobe_seq`

## Requirements
- R1: A machine cycle is 12 clocks, counted from reset release as slots 0 to 11. Outside a data strobe half, `ale` is high in slots 1, 2, 7 and 8 and low elsewhere, which gives a pulse every 6 clocks.
- R2: While `rst_n` is low, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `lo_sel` is 0 and `hi_addr` is 0.
- R3: The fetch mode of each half is sampled on the clock edge that ends the previous half. Those edges are at slots 5 and 11, and the first half after reset counts as internal. A half is external when `code_int_en` is 0 or `fetch_addr` is above 0x1FFF. Otherwise it is internal.
- R4: `psen_n` is low only in slots 3 to 5 of an external-fetch half with no data access under way. It is never low in an internal-fetch half.
- R5: A request is taken only when `xreq` is high on the clock edge that ends slot 5 while no access is under way. `xreq` at any other slot, or during an access, has no effect on `rd_n` or `wr_n`.
- R6: An accepted access turns slots 6 to 11 into the address half and slots 0 to 5 of the next machine cycle into the strobe half. `psen_n` stays high in both halves. `ale` still pulses in the address half but stays low through the whole strobe half.
- R7: During the strobe half, `rd_n` is low for all 6 slots when the captured `xwrite` was 0. `wr_n` is low for all 6 slots when it was 1. The two are never low together.
- R8: `lo_sel` codes are 0 port data, 1 address, 2 floating and 3 write data. In an external-fetch half it is 1 in slots 0 to 2 and 2 in slots 3 to 5. In an internal-fetch half it is 0. In the address half it is 1 in slots 6 to 8, then 3 for a write or 2 for a read. In the strobe half it is 3 for a write or 2 for a read, so the lines float before `rd_n` falls.
- R9: `hi_addr` is 1 for the whole of an external-fetch half and 0 for an internal-fetch half. In the address and strobe halves it equals the captured `xwide`: 1 drives the high data address byte, 0 leaves the port register on the lines.
- R10: `bus_addr` shows the fetch address sampled at the start of the current half in fetch halves. In the address and strobe halves it shows `xaddr` as captured with the request.
- R11: With parameter `INT_CODE` = 0, every fetch half after the first is external, whatever `code_int_en` and `fetch_addr` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_int_en | input | 1 | 1 lets low addresses fetch from internal code memory |
| fetch_addr | input | 16 | Address of the next code fetch |
| xreq | input | 1 | External data access request |
| xwrite | input | 1 | 1 write, 0 read, captured with the request |
| xwide | input | 1 | 1 for a 16-bit data address, 0 for an 8-bit one |
| xaddr | input | 16 | Data address, captured with the request |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_sel | output | 2 | Source for the low address/data lines |
| hi_addr | output | 1 | 1 drives the address high byte on the high lines |
| bus_addr | output | 16 | Address to present on the lines |

## Verification
A slot counter that is off by one moves every strobe a clock early or late. This shows on `ale` within 2 clocks of reset release. A stale fetch decision flips `psen_n`, `lo_sel` and `hi_addr` for the whole of the next half, within 6 clocks. A data state machine stuck in, or skipping, its address or strobe half shows up several ways within one machine cycle. An extra or missing `ale` pulse appears, `psen_n` falls where it should stay high, or the data strobe is short or absent. The bench compares every output on every clock of a sweep. That sweep covers pin level, four boundary fetch addresses, four access kinds and three request timings, so each of these errors is caught on the clock where it first appears.

// File: rtl/xbus_seq_pkg.sv
`timescale 1ns/1ps
package xbus_seq_pkg;

   // drive source for the multiplexed low address/data lines
   typedef enum logic [1:0] {
      LO_PORT  = 2'd0,
      LO_ADDR  = 2'd1,
      LO_FLOAT = 2'd2,
      LO_WDATA = 2'd3
   } lo_src_e;

   // progress of one external data access
   typedef enum logic [1:0] {
      DX_IDLE   = 2'd0,
      DX_ADDR   = 2'd1,
      DX_STROBE = 2'd2
   } dx_state_e;

   typedef struct packed {
      logic wr;
      logic wide;
   } dx_attr_t;

endpackage

// File: rtl/xbus_phase_div.sv
`timescale 1ns/1ps
// divide-by-two stage: the phase flips on every clock, so the clock duty
// cycle never reaches the strobe timing
module xbus_phase_div (
   input  logic clk,
   input  logic rst_n,
   output logic phase_o
);
   logic ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= 1'b0;
      else        ph_q <= ~ph_q;
   end

   assign phase_o = ph_q;
endmodule

// File: rtl/xbus_state_ctr.sv
`timescale 1ns/1ps
// state counter of the machine cycle; slot = state*2 + phase
module xbus_state_ctr #(
   parameter int NSTATE = 6,
   localparam int STW   = $clog2(NSTATE),
   localparam int SW    = STW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          phase_i,
   output logic [SW-1:0] sub_o,
   output logic          upper_o,
   output logic          half_last_o
);
   localparam int SLOTS = 2 * NSTATE;
   localparam int HALF  = NSTATE;
   localparam logic [STW-1:0] ST_LAST   = STW'(NSTATE - 1);
   localparam logic [SW-1:0]  SL_HALF   = SW'(HALF);
   localparam logic [SW-1:0]  SL_HLAST  = SW'(HALF - 1);
   localparam logic [SW-1:0]  SL_LAST   = SW'(SLOTS - 1);

   logic [STW-1:0] state_q;
   logic [SW-1:0]  slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
      end else if (phase_i) begin
         if (state_q == ST_LAST) state_q <= '0;
         else                    state_q <= state_q + 1'b1;
      end
   end

   assign slot        = {state_q, phase_i};
   assign upper_o     = (slot >= SL_HALF);
   assign sub_o       = upper_o ? (slot - SL_HALF) : slot;
   assign half_last_o = (slot == SL_HLAST) || (slot == SL_LAST);

   // R1: the last slot of a machine cycle is followed by slot 0
   assert_cycle_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SL_LAST) |=> (slot == '0));

   // R1: each half is followed by the other half
   assert_half_alt_R1: assert property (@(posedge clk) disable iff (!rst_n)
      half_last_o |=> (upper_o != $past(upper_o)));
endmodule

// File: rtl/xbus_access_fsm.sv
`timescale 1ns/1ps
// per-half fetch decision and the two-half data access sequence
module xbus_access_fsm
   import xbus_seq_pkg::*;
#(
   parameter int              AW       = 16,
   parameter bit              INT_CODE = 1'b1,
   parameter logic [AW-1:0]   INT_TOP  = AW'(16'h1FFF)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          half_last_i,
   input  logic          upper_i,
   input  logic          code_int_en_i,
   input  logic [AW-1:0] fetch_addr_i,
   input  logic          xreq_i,
   input  logic          xwrite_i,
   input  logic          xwide_i,
   input  logic [AW-1:0] xaddr_i,
   output dx_state_e     dx_o,
   output logic          fetch_ext_o,
   output dx_attr_t      attr_o,
   output logic [AW-1:0] fa_o,
   output logic [AW-1:0] xa_o
);
   dx_state_e     dx_q;
   logic          ext_q;
   dx_attr_t      attr_q;
   logic [AW-1:0] fa_q;
   logic [AW-1:0] xa_q;
   logic          want_ext;
   logic          take_req;

   generate
      if (INT_CODE) begin : g_int_code
         logic in_window;
         assign in_window = (fetch_addr_i <= INT_TOP);
         assign want_ext  = !(code_int_en_i && in_window);
      end else begin : g_no_int_code
         assign want_ext = 1'b1;
      end
   endgenerate

   assign take_req = half_last_i && !upper_i && (dx_q == DX_IDLE) && xreq_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dx_q   <= DX_IDLE;
         ext_q  <= 1'b0;
         attr_q <= '0;
         fa_q   <= '0;
         xa_q   <= '0;
      end else if (half_last_i) begin
         ext_q <= want_ext;
         fa_q  <= fetch_addr_i;
         unique case (dx_q)
            DX_IDLE: begin
               if (take_req) begin
                  dx_q        <= DX_ADDR;
                  attr_q.wr   <= xwrite_i;
                  attr_q.wide <= xwide_i;
                  xa_q        <= xaddr_i;
               end
            end
            DX_ADDR:   if (upper_i)  dx_q <= DX_STROBE;
            DX_STROBE: if (!upper_i) dx_q <= DX_IDLE;
            default:   dx_q <= DX_IDLE;
         endcase
      end
   end

   assign dx_o        = dx_q;
   assign fetch_ext_o = ext_q;
   assign attr_o      = attr_q;
   assign fa_o        = fa_q;
   assign xa_o        = xa_q;

   // R5: a request outside the end of slot 5 leaves an idle sequencer idle
   assert_req_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dx_q == DX_IDLE && xreq_i && !(half_last_i && !upper_i)) |=> (dx_q == DX_IDLE));

   // R6: the address half always leads into the strobe half
   assert_addr_then_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dx_q == DX_ADDR && half_last_i) |=> (dx_q == DX_STROBE));

   // R7: the strobe half is never cut short
   assert_strobe_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dx_q == DX_STROBE && !half_last_i) |=> (dx_q == DX_STROBE));
endmodule

// File: rtl/xbus_strobe_dec.sv
`timescale 1ns/1ps
// decodes slot, fetch mode and access state into strobes and selects
module xbus_strobe_dec
   import xbus_seq_pkg::*;
#(
   parameter int  NSTATE = 6,
   parameter int  AW     = 16,
   localparam int SW     = $clog2(NSTATE) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] sub_i,
   input  dx_state_e     dx_i,
   input  logic          fetch_ext_i,
   input  dx_attr_t      attr_i,
   input  logic [AW-1:0] fa_i,
   input  logic [AW-1:0] xa_i,
   output logic          ale_o,
   output logic          psen_n_o,
   output logic          rd_n_o,
   output logic          wr_n_o,
   output lo_src_e       lo_sel_o,
   output logic          hi_addr_o,
   output logic [AW-1:0] bus_addr_o
);
   localparam logic [SW-1:0] ALE_FIRST  = SW'(1);
   localparam logic [SW-1:0] ALE_LAST   = SW'(2);
   localparam logic [SW-1:0] PSEN_FIRST = SW'(3);

   logic ale_win, psen_win, in_strobe, in_idle, late;

   assign ale_win   = (sub_i >= ALE_FIRST) && (sub_i <= ALE_LAST);
   assign psen_win  = (sub_i >= PSEN_FIRST);
   assign late      = psen_win;
   assign in_strobe = (dx_i == DX_STROBE);
   assign in_idle   = (dx_i == DX_IDLE);

   assign ale_o    = ale_win && !in_strobe;
   assign psen_n_o = !(psen_win && fetch_ext_i && in_idle);
   assign rd_n_o   = !(in_strobe && !attr_i.wr);
   assign wr_n_o   = !(in_strobe && attr_i.wr);

   always_comb begin
      unique case (dx_i)
         DX_ADDR: begin
            if (!late)          lo_sel_o = LO_ADDR;
            else if (attr_i.wr) lo_sel_o = LO_WDATA;
            else                lo_sel_o = LO_FLOAT;
            hi_addr_o  = attr_i.wide;
            bus_addr_o = xa_i;
         end
         DX_STROBE: begin
            lo_sel_o   = attr_i.wr ? LO_WDATA : LO_FLOAT;
            hi_addr_o  = attr_i.wide;
            bus_addr_o = xa_i;
         end
         default: begin
            if (!fetch_ext_i) lo_sel_o = LO_PORT;
            else if (!late)   lo_sel_o = LO_ADDR;
            else              lo_sel_o = LO_FLOAT;
            hi_addr_o  = fetch_ext_i;
            bus_addr_o = fa_i;
         end
      endcase
   end

   // R8: the low lines have been released before the read strobe falls
   assert_float_before_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n_o) |-> ($past(lo_sel_o) == LO_FLOAT));

   // R6: no code strobe and no latch strobe while a data strobe is low
   assert_quiet_in_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n_o || !wr_n_o) |-> (psen_n_o && !ale_o));

   // R1: every latch pulse is two clocks wide
   assert_ale_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale_o) |=> ale_o);

   // R7: read and write strobes exclude each other
   assert_rdwr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n_o && !wr_n_o));
endmodule

// File: rtl/xbus_strobe_seq.sv
`timescale 1ns/1ps
module xbus_strobe_seq
   import xbus_seq_pkg::*;
#(
   parameter int            NSTATE   = 6,
   parameter int            AW       = 16,
   parameter bit            INT_CODE = 1'b1,
   parameter logic [AW-1:0] INT_TOP  = AW'(16'h1FFF)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          code_int_en,
   input  logic [AW-1:0] fetch_addr,
   input  logic          xreq,
   input  logic          xwrite,
   input  logic          xwide,
   input  logic [AW-1:0] xaddr,
   output logic          ale,
   output logic          psen_n,
   output logic          rd_n,
   output logic          wr_n,
   output logic [1:0]    lo_sel,
   output logic          hi_addr,
   output logic [AW-1:0] bus_addr
);
   localparam int SW = $clog2(NSTATE) + 1;

   generate
      if (NSTATE < 4 || (NSTATE % 2) != 0) begin : g_bad_nstate
         $error("xbus_strobe_seq: NSTATE must be even and at least 4");
      end
      if (AW < 9) begin : g_bad_aw
         $error("xbus_strobe_seq: AW must be at least 9");
      end
   endgenerate

   logic          phase;
   logic [SW-1:0] sub;
   logic          upper, half_last;
   dx_state_e     dx;
   logic          fetch_ext;
   dx_attr_t      attr;
   logic [AW-1:0] fa, xa;
   lo_src_e       lo_src;

   xbus_phase_div u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_o (phase)
   );

   xbus_state_ctr #(.NSTATE(NSTATE)) u_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase_i     (phase),
      .sub_o       (sub),
      .upper_o     (upper),
      .half_last_o (half_last)
   );

   xbus_access_fsm #(.AW(AW), .INT_CODE(INT_CODE), .INT_TOP(INT_TOP)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .half_last_i   (half_last),
      .upper_i       (upper),
      .code_int_en_i (code_int_en),
      .fetch_addr_i  (fetch_addr),
      .xreq_i        (xreq),
      .xwrite_i      (xwrite),
      .xwide_i       (xwide),
      .xaddr_i       (xaddr),
      .dx_o          (dx),
      .fetch_ext_o   (fetch_ext),
      .attr_o        (attr),
      .fa_o          (fa),
      .xa_o          (xa)
   );

   xbus_strobe_dec #(.NSTATE(NSTATE), .AW(AW)) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .sub_i       (sub),
      .dx_i        (dx),
      .fetch_ext_i (fetch_ext),
      .attr_i      (attr),
      .fa_i        (fa),
      .xa_i        (xa),
      .ale_o       (ale),
      .psen_n_o    (psen_n),
      .rd_n_o      (rd_n),
      .wr_n_o      (wr_n),
      .lo_sel_o    (lo_src),
      .hi_addr_o   (hi_addr),
      .bus_addr_o  (bus_addr)
   );

   assign lo_sel = lo_src;
endmodule

// File: tb/tb_xbus_strobe_seq.sv
`timescale 1ns/1ps
module tb_xbus_strobe_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        code_int_en = 1'b0;
   logic [15:0] fetch_addr = 16'h0;
   logic        xreq = 1'b0, xwrite = 1'b0, xwide = 1'b0;
   logic [15:0] xaddr = 16'h0;
   logic        ale, psen_n, rd_n, wr_n, hi_addr;
   logic [1:0]  lo_sel;
   logic [15:0] bus_addr;
   logic        ale2, psen2_n, rd2_n, wr2_n, hi2;
   logic [1:0]  lo2;
   logic [15:0] bus2;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // bench model state, from the requirements
   int        m_slot = 0, m_ds = 0;
   bit        m_hx = 0, m_hx2 = 0, m_wr = 0, m_wide = 0;
   logic [15:0] m_fa = 0, m_xa = 0;
   int        req_mode = 0;

   always #5 clk = ~clk;   // 100 MHz

   xbus_strobe_seq dut (
      .clk(clk), .rst_n(rst_n), .code_int_en(code_int_en), .fetch_addr(fetch_addr),
      .xreq(xreq), .xwrite(xwrite), .xwide(xwide), .xaddr(xaddr),
      .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
      .lo_sel(lo_sel), .hi_addr(hi_addr), .bus_addr(bus_addr));

   xbus_strobe_seq #(.INT_CODE(1'b0)) dut_nocode (
      .clk(clk), .rst_n(rst_n), .code_int_en(code_int_en), .fetch_addr(fetch_addr),
      .xreq(xreq), .xwrite(xwrite), .xwide(xwide), .xaddr(xaddr),
      .ale(ale2), .psen_n(psen2_n), .rd_n(rd2_n), .wr_n(wr2_n),
      .lo_sel(lo2), .hi_addr(hi2), .bus_addr(bus2));

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s slot=%0d actual=%0h expected=%0h", req, m_slot, act, exp);
      end
   endtask

   function automatic bit is_ext(input bit en, input logic [15:0] a);
      return !en || (a > 16'h1FFF);
   endfunction

   // one clock: advance the model at the edge, compare after the edge
   task automatic tick();
      int sub, exp_lo;
      bit exp_ale, exp_psen_n, exp_hi, late;
      logic [15:0] exp_bus;
      @(posedge clk);
      if (m_slot == 5 || m_slot == 11) begin
         m_hx  = is_ext(code_int_en, fetch_addr);
         m_hx2 = 1'b1;
         m_fa  = fetch_addr;
         if (m_slot == 5) begin
            if (m_ds == 0 && xreq) begin
               m_ds = 1; m_wr = xwrite; m_wide = xwide; m_xa = xaddr;
            end else if (m_ds == 2) m_ds = 0;
         end else if (m_ds == 1) m_ds = 2;
      end
      m_slot = (m_slot + 1) % 12;
      @(negedge clk);
      sub  = m_slot % 6;
      late = (sub >= 3);
      exp_ale    = (sub == 1 || sub == 2) && (m_ds != 2);
      exp_psen_n = !(late && m_hx && m_ds == 0);
      if (m_ds == 0) begin
         exp_lo  = !m_hx ? 0 : (late ? 2 : 1);
         exp_hi  = m_hx;
         exp_bus = m_fa;
      end else begin
         if (m_ds == 1 && !late) exp_lo = 1;
         else exp_lo = m_wr ? 3 : 2;
         exp_hi  = m_wide;
         exp_bus = m_xa;
      end
      chk((m_ds == 2) ? "R6 ale" : "R1 ale", int'(ale), int'(exp_ale));
      if (m_ds != 0)  chk("R6 psen_n", int'(psen_n), int'(exp_psen_n));
      else if (late)  chk("R3 psen_n", int'(psen_n), int'(exp_psen_n));
      else            chk("R4 psen_n", int'(psen_n), int'(exp_psen_n));
      chk((req_mode != 0) ? "R5 rd_n" : "R7 rd_n", int'(rd_n), int'(!(m_ds == 2 && !m_wr)));
      chk((req_mode != 0) ? "R5 wr_n" : "R7 wr_n", int'(wr_n), int'(!(m_ds == 2 && m_wr)));
      chk("R8 lo_sel", int'(lo_sel), exp_lo);
      chk("R9 hi_addr", int'(hi_addr), int'(exp_hi));
      chk("R10 bus_addr", int'(bus_addr), int'(exp_bus));
      chk("R11 psen_n", int'(psen2_n), int'(!(late && m_hx2 && m_ds == 0)));
   endtask

   initial begin
      logic [15:0] addrs [4];
      addrs[0] = 16'h0000; addrs[1] = 16'h1FFF; addrs[2] = 16'h2000; addrs[3] = 16'hFFFF;
      repeat (3) @(negedge clk);
      // R2: reset state
      chk("R2 ale", int'(ale), 0);
      chk("R2 psen_n", int'(psen_n), 1);
      chk("R2 rd_n", int'(rd_n), 1);
      chk("R2 wr_n", int'(wr_n), 1);
      chk("R2 lo_sel", int'(lo_sel), 0);
      chk("R2 hi_addr", int'(hi_addr), 0);
      rst_n = 1'b1;
      for (int en = 0; en < 2; en++)
         for (int ai = 0; ai < 4; ai++)
            for (int kind = 0; kind < 5; kind++)
               for (int rm = 0; rm < 3; rm++) begin
                  code_int_en = en[0];
                  fetch_addr  = addrs[ai] ^ 16'(ai * 3 + en);
                  if (ai == 1 || ai == 2) fetch_addr = addrs[ai];
                  xaddr   = 16'hA500 ^ 16'((en * 60 + ai * 15 + kind * 3 + rm) * 257);
                  xwrite  = (kind == 2 || kind == 4);
                  xwide   = (kind == 3 || kind == 4);
                  req_mode = rm;
                  if (kind == 0) begin
                     repeat (24) tick();
                  end else if (rm == 2) begin
                     xreq = 1'b1;
                     repeat (36) tick();
                     xreq = 1'b0;
                     repeat (24) tick();
                  end else begin
                     while (m_slot != ((rm == 0) ? 5 : 3)) tick();
                     xreq = 1'b1;
                     tick();
                     xreq = 1'b0;
                     repeat (30) tick();
                  end
               end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule